// File: doc/BRIEF.md
# Rectangular Window Write Engine

This block accepts a stream of 16-bit host words that fill a rectangular window of a frame buffer. A small configuration port loads the window's start and end columns and rows, a four-bit pixel format code and a three-bit data-source selector. A transfer is set up when the selector is written, or implicitly when a data word arrives while nothing is pending. Setup validates the window and computes how many 16-bit words the window occupies. Each later data word is turned into a frame-buffer write that carries the pixel address and the byte offset within that pixel.

When the last word of a window is taken, the engine reports completion and widens a running dirty bounding box so that it covers the window. The display refresh logic empties this box with a refresh pulse, or forces it to cover the whole panel with an invalidate pulse.

The sequencer has two states. `ST_IDLE` means no transfer is pending. `ST_STREAM` means words are still expected. The transition IDLE to STREAM is taken on a successful setup whose window needs more than the word that arrived with it. STREAM to IDLE is taken when the remaining count reaches zero. STREAM to STREAM, with the count reloaded, is taken when the selector is written again and setup succeeds. A failed setup never changes the state.

Top module: `win_xfer_engine`

## Requirements
- R1: After reset the engine is idle. `busy`, `words_left`, `fb_we`, `xfer_done` and `setup_err` are 0. The dirty box is empty: x0 = PANEL_W, x1 = 0, y0 = PANEL_H, y1 = 0.
- R2: Config select codes are 0 start column, 1 end column, 2 start row, 3 end row, 4 format, 5 source. Codes 6 and 7 are ignored. Format codes map to bytes per pixel as follows: 1 gives 2, 2 and 3 give 3, 6 and 7 give 4, and every other code gives 0. The format resets to 3 and the coordinates and source reset to 0.
- R3: Setup fails when the source is above 3, when bytes per pixel is 0, when end column < start column, or when end row < start row. A failed setup pulses `setup_err` for one cycle and leaves the state and count unchanged.
- R4: A successful setup loads bpp × (xe−xs+1) × (ye−ys+1) / 2 words, rounded down. `busy` stays 1 until that many words have been taken.
- R5: A source write keeps only the 3 low bits of the written value, so 0x0B selects source 3 and 0x0C selects source 4.
- R6: A source write performs setup in the same cycle. If a transfer is pending, a successful setup restarts it with a fresh count.
- R7: A data word arriving while idle first attempts setup. On success it becomes the first word of the window. On failure the word is dropped: no `fb_we` and `setup_err` is pulsed.
- R8: Each word is written at pixel address (ys+row)×PANEL_W + xs + col, with byte offset `fb_byte`. The first word is at col 0, row 0, byte 0. The byte offset advances by 2 per word and wraps modulo bpp, and each wrap advances the column. The column wraps to 0 at the window width and then advances the row.
- R9: `fb_we`, `fb_addr`, `fb_byte` and `fb_wdata` appear one cycle after the accepted data word, and `fb_wdata` equals that word.
- R10: `xfer_done` pulses together with the `fb_we` of the last word. After that pulse the engine is idle with `words_left` = 0.
- R11: A completed window widens the dirty box. x0 and y0 become the minimum of the old value and the start. x1 and y1 become the maximum of the old value and end+1.
- R12: `refresh_done` empties the dirty box. A window that completes in the same cycle is folded into the empty box.
- R13: `invalidate` sets the dirty box to the full panel (0, PANEL_W, 0, PANEL_H) and overrides refresh and commit.
- R14: `dirty_none` is 1 exactly when x1 ≤ x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field select |
| cfg_wdata | input | CRD_W | Configuration write value |
| dp_we | input | 1 | Data-port word strobe |
| dp_wdata | input | 16 | Data-port word |
| refresh_done | input | 1 | Empty the dirty box |
| invalidate | input | 1 | Mark the whole panel dirty |
| fb_we | output | 1 | Frame-buffer write strobe |
| fb_addr | output | AW | Pixel address of the write |
| fb_byte | output | 2 | Byte offset within the pixel |
| fb_wdata | output | 16 | Word to write |
| busy | output | 1 | Transfer pending |
| words_left | output | CW | Words still expected |
| xfer_done | output | 1 | Window completed |
| setup_err | output | 1 | Setup attempt rejected |
| dirty_x0 | output | CRD_W+1 | Dirty box left edge |
| dirty_x1 | output | CRD_W+1 | Dirty box right edge, exclusive |
| dirty_y0 | output | CRD_W+1 | Dirty box top edge |
| dirty_y1 | output | CRD_W+1 | Dirty box bottom edge, exclusive |
| dirty_none | output | 1 | Dirty box is empty |

## Verification
The embedded properties check, on every cycle, the following:
- the count stays nonzero while streaming;
- the byte offset stays below the latched pixel size;
- each frame-buffer write follows a data word;
- completion coincides with a write;
- the source field is masked;
- the dirty box responds to refresh, invalidate and commit.

Only the bench scenarios can show the rest:
- the exact word count for each format;
- the full address walk across row wraps for three- and four-byte pixels;
- dropping of words after a rejected implicit setup;
- restart of a pending transfer;
- folding of a commit into a box emptied in the same cycle.

// File: rtl/wx_pkg.sv
package wx_pkg;

    typedef enum logic [2:0] {
        SEL_XS  = 3'd0,
        SEL_XE  = 3'd1,
        SEL_YS  = 3'd2,
        SEL_YE  = 3'd3,
        SEL_FMT = 3'd4,
        SEL_SRC = 3'd5
    } cfg_sel_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } wx_state_e;

    // bytes per pixel for a format code, 0 for unsupported codes
    function automatic logic [2:0] fmt_to_bpp(input logic [3:0] code);
        logic [2:0] r;
        unique case (code)
            4'd1:        r = 3'd2;
            4'd2, 4'd3:  r = 3'd3;
            4'd6, 4'd7:  r = 3'd4;
            default:     r = 3'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wx_win_cfg.sv
module wx_win_cfg
    import wx_pkg::*;
#(
    parameter int CRD_W = 10,
    parameter int CW    = 2 * CRD_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [CRD_W-1:0] cfg_wdata,
    output logic [CRD_W-1:0] xs,
    output logic [CRD_W-1:0] xe,
    output logic [CRD_W-1:0] ys,
    output logic [CRD_W-1:0] ye,
    output logic [2:0]       bpp,
    output logic             src_write,
    output logic             setup_ok,
    output logic [CW-1:0]    setup_words
);
    localparam int DW = CRD_W + 1;
    localparam int PW = CW + 1;

    logic [3:0]    fmt_q;
    logic [2:0]    src_q;
    logic [2:0]    src_eff;
    logic [DW-1:0] w, h;
    logic [PW-1:0] prod;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xs    <= '0;
            xe    <= '0;
            ys    <= '0;
            ye    <= '0;
            fmt_q <= 4'd3;
            src_q <= 3'd0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_XS:  xs    <= cfg_wdata;
                SEL_XE:  xe    <= cfg_wdata;
                SEL_YS:  ys    <= cfg_wdata;
                SEL_YE:  ye    <= cfg_wdata;
                SEL_FMT: fmt_q <= cfg_wdata[3:0];
                SEL_SRC: src_q <= cfg_wdata[2:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        src_write   = cfg_we && (cfg_sel == SEL_SRC);
        src_eff     = src_write ? cfg_wdata[2:0] : src_q;
        bpp         = fmt_to_bpp(fmt_q);
        w           = {1'b0, xe} - {1'b0, xs} + DW'(1);
        h           = {1'b0, ye} - {1'b0, ys} + DW'(1);
        prod        = PW'(bpp) * PW'(w) * PW'(h);
        setup_words = CW'(prod >> 1);
        setup_ok    = (src_eff <= 3'd3) && (bpp != 3'd0) &&
                      (xe >= xs) && (ye >= ys);
    end

    // R5: only the three low bits of a source write are kept
    p_src_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        src_write |=> (src_q == $past(cfg_wdata[2:0])));

endmodule

// File: rtl/wx_seq.sv
module wx_seq
    import wx_pkg::*;
#(
    parameter int CRD_W   = 10,
    parameter int CW      = 2 * CRD_W + 2,
    parameter int AW      = 20,
    parameter int PANEL_W = 320
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dp_we,
    input  logic [15:0]      dp_wdata,
    input  logic             src_write,
    input  logic             setup_ok,
    input  logic [CW-1:0]    setup_words,
    input  logic [CRD_W-1:0] xs,
    input  logic [CRD_W-1:0] xe,
    input  logic [CRD_W-1:0] ys,
    input  logic [CRD_W-1:0] ye,
    input  logic [2:0]       bpp,
    output logic             fb_we,
    output logic [AW-1:0]    fb_addr,
    output logic [1:0]       fb_byte,
    output logic [15:0]      fb_wdata,
    output logic             busy,
    output logic [CW-1:0]    words_left,
    output logic             xfer_done,
    output logic             setup_err,
    output logic             commit,
    output logic [CRD_W:0]   cm_x0,
    output logic [CRD_W:0]   cm_x1,
    output logic [CRD_W:0]   cm_y0,
    output logic [CRD_W:0]   cm_y1
);
    localparam int DW = CRD_W + 1;

    wx_state_e        state_q, state_d;
    logic [CW-1:0]    rem_q, rem_d;
    logic [CRD_W-1:0] col_q, col_d;
    logic [2:0]       byte_q, byte_d;
    logic [AW-1:0]    rowb_q, rowb_d;
    logic [CRD_W-1:0] lxs_q, lxe_q, lys_q, lye_q;
    logic [2:0]       lbpp_q;

    // current pointer: fresh window on setup, latched otherwise
    logic [CW-1:0]    c_rem;
    logic [CRD_W-1:0] c_col, c_xs, c_xe, c_ys, c_ye;
    logic [2:0]       c_byte, c_bpp, b_sum;
    logic [AW-1:0]    c_rowb, addr;
    logic [DW-1:0]    c_w, col_inc;
    logic             trig, do_setup, err, take, last, wrap;

    always_comb begin
        trig     = src_write || (dp_we && state_q == ST_IDLE);
        do_setup = trig && setup_ok;
        err      = trig && !setup_ok;
        take     = dp_we && (state_q == ST_STREAM || do_setup);

        if (do_setup) begin
            c_rem  = setup_words;
            c_col  = '0;
            c_byte = 3'd0;
            c_rowb = AW'(ys) * AW'(PANEL_W);
            c_xs   = xs;
            c_xe   = xe;
            c_ys   = ys;
            c_ye   = ye;
            c_bpp  = bpp;
        end else begin
            c_rem  = rem_q;
            c_col  = col_q;
            c_byte = byte_q;
            c_rowb = rowb_q;
            c_xs   = lxs_q;
            c_xe   = lxe_q;
            c_ys   = lys_q;
            c_ye   = lye_q;
            c_bpp  = lbpp_q;
        end

        c_w     = {1'b0, c_xe} - {1'b0, c_xs} + DW'(1);
        addr    = c_rowb + AW'(c_xs) + AW'(c_col);
        b_sum   = c_byte + 3'd2;
        wrap    = (b_sum >= c_bpp);
        col_inc = {1'b0, c_col} + DW'(1);
        last    = take && (c_rem == CW'(1));

        state_d = state_q;
        rem_d   = rem_q;
        col_d   = col_q;
        byte_d  = byte_q;
        rowb_d  = rowb_q;
        if (take) begin
            rem_d  = c_rem - CW'(1);
            byte_d = wrap ? (b_sum - c_bpp) : b_sum;
            col_d  = c_col;
            rowb_d = c_rowb;
            if (wrap) begin
                if (col_inc == c_w) begin
                    col_d  = '0;
                    rowb_d = c_rowb + AW'(PANEL_W);
                end else begin
                    col_d  = col_inc[CRD_W-1:0];
                end
            end
            state_d = last ? ST_IDLE : ST_STREAM;
        end else if (do_setup) begin
            rem_d   = c_rem;
            col_d   = c_col;
            byte_d  = c_byte;
            rowb_d  = c_rowb;
            state_d = ST_STREAM;
        end

        commit = last;
        cm_x0  = {1'b0, c_xs};
        cm_x1  = {1'b0, c_xe} + DW'(1);
        cm_y0  = {1'b0, c_ys};
        cm_y1  = {1'b0, c_ye} + DW'(1);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            col_q   <= '0;
            byte_q  <= 3'd0;
            rowb_q  <= '0;
            lxs_q   <= '0;
            lxe_q   <= '0;
            lys_q   <= '0;
            lye_q   <= '0;
            lbpp_q  <= 3'd2;
        end else begin
            unique case (state_d)
                ST_IDLE, ST_STREAM: state_q <= state_d;
            endcase
            rem_q  <= rem_d;
            col_q  <= col_d;
            byte_q <= byte_d;
            rowb_q <= rowb_d;
            if (do_setup) begin
                lxs_q  <= xs;
                lxe_q  <= xe;
                lys_q  <= ys;
                lye_q  <= ye;
                lbpp_q <= bpp;
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_we     <= 1'b0;
            fb_addr   <= '0;
            fb_byte   <= 2'd0;
            fb_wdata  <= '0;
            xfer_done <= 1'b0;
            setup_err <= 1'b0;
        end else begin
            fb_we     <= take;
            fb_addr   <= addr;
            fb_byte   <= c_byte[1:0];
            fb_wdata  <= dp_wdata;
            xfer_done <= last;
            setup_err <= err;
        end
    end

    assign busy       = (state_q == ST_STREAM);
    assign words_left = rem_q;

    // R4: a pending transfer always expects at least one word
    p_stream_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM) |-> (rem_q != '0));
    // R8: byte offset stays inside the latched pixel
    p_byte_in_pixel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM) |-> (byte_q < lbpp_q));
    // R9: every frame-buffer write follows a data word
    p_fb_follows_dp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> $past(dp_we));
    // R10: completion coincides with the last write, then idle
    p_done_with_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (fb_we && words_left == '0));

endmodule

// File: rtl/wx_dirty.sv
module wx_dirty #(
    parameter int CRD_W   = 10,
    parameter int PANEL_W = 320,
    parameter int PANEL_H = 240
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           refresh_done,
    input  logic           invalidate,
    input  logic           commit,
    input  logic [CRD_W:0] cm_x0,
    input  logic [CRD_W:0] cm_x1,
    input  logic [CRD_W:0] cm_y0,
    input  logic [CRD_W:0] cm_y1,
    output logic [CRD_W:0] x0,
    output logic [CRD_W:0] x1,
    output logic [CRD_W:0] y0,
    output logic [CRD_W:0] y1,
    output logic           none
);
    localparam int DW = CRD_W + 1;
    localparam logic [DW-1:0] PWV = DW'(PANEL_W);
    localparam logic [DW-1:0] PHV = DW'(PANEL_H);

    logic [DW-1:0] bx0, bx1, by0, by1;
    logic [DW-1:0] nx0, nx1, ny0, ny1;

    always_comb begin
        if (refresh_done) begin
            bx0 = PWV; bx1 = '0; by0 = PHV; by1 = '0;
        end else begin
            bx0 = x0;  bx1 = x1; by0 = y0;  by1 = y1;
        end
        nx0 = bx0; nx1 = bx1; ny0 = by0; ny1 = by1;
        if (commit) begin
            nx0 = (cm_x0 < bx0) ? cm_x0 : bx0;
            nx1 = (cm_x1 > bx1) ? cm_x1 : bx1;
            ny0 = (cm_y0 < by0) ? cm_y0 : by0;
            ny1 = (cm_y1 > by1) ? cm_y1 : by1;
        end
        if (invalidate) begin
            nx0 = '0; nx1 = PWV; ny0 = '0; ny1 = PHV;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x0 <= PWV; x1 <= '0; y0 <= PHV; y1 <= '0;
        end else begin
            x0 <= nx0; x1 <= nx1; y0 <= ny0; y1 <= ny1;
        end
    end

    assign none = (x1 <= x0);

    // R11: a committed window is covered afterwards
    p_commit_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !invalidate) |=> (x0 <= $past(cm_x0) && x1 >= $past(cm_x1) &&
                                     y0 <= $past(cm_y0) && y1 >= $past(cm_y1)));
    // R12: refresh alone leaves an empty box
    p_refresh_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_done && !invalidate && !commit) |=>
            (x0 == PWV && x1 == '0 && y0 == PHV && y1 == '0 && none));
    // R13: invalidate marks the whole panel
    p_invalidate_full_r13: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |=> (x0 == '0 && x1 == PWV && y0 == '0 && y1 == PHV && !none));

endmodule

// File: rtl/win_xfer_engine.sv
module win_xfer_engine #(
    parameter int CRD_W   = 10,
    parameter int PANEL_W = 320,
    parameter int PANEL_H = 240,
    parameter int CW      = 2 * CRD_W + 2,
    parameter int AW      = CRD_W + $clog2(PANEL_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [CRD_W-1:0] cfg_wdata,
    input  logic             dp_we,
    input  logic [15:0]      dp_wdata,
    input  logic             refresh_done,
    input  logic             invalidate,
    output logic             fb_we,
    output logic [AW-1:0]    fb_addr,
    output logic [1:0]       fb_byte,
    output logic [15:0]      fb_wdata,
    output logic             busy,
    output logic [CW-1:0]    words_left,
    output logic             xfer_done,
    output logic             setup_err,
    output logic [CRD_W:0]   dirty_x0,
    output logic [CRD_W:0]   dirty_x1,
    output logic [CRD_W:0]   dirty_y0,
    output logic [CRD_W:0]   dirty_y1,
    output logic             dirty_none
);
    logic [CRD_W-1:0] xs, xe, ys, ye;
    logic [2:0]       bpp;
    logic             src_write, setup_ok, commit;
    logic [CW-1:0]    setup_words;
    logic [CRD_W:0]   cm_x0, cm_x1, cm_y0, cm_y1;

    wx_win_cfg #(.CRD_W(CRD_W), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .xs(xs), .xe(xe), .ys(ys), .ye(ye),
        .bpp(bpp), .src_write(src_write), .setup_ok(setup_ok),
        .setup_words(setup_words)
    );

    wx_seq #(.CRD_W(CRD_W), .CW(CW), .AW(AW), .PANEL_W(PANEL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .dp_we(dp_we), .dp_wdata(dp_wdata),
        .src_write(src_write), .setup_ok(setup_ok), .setup_words(setup_words),
        .xs(xs), .xe(xe), .ys(ys), .ye(ye), .bpp(bpp),
        .fb_we(fb_we), .fb_addr(fb_addr), .fb_byte(fb_byte), .fb_wdata(fb_wdata),
        .busy(busy), .words_left(words_left), .xfer_done(xfer_done),
        .setup_err(setup_err), .commit(commit),
        .cm_x0(cm_x0), .cm_x1(cm_x1), .cm_y0(cm_y0), .cm_y1(cm_y1)
    );

    wx_dirty #(.CRD_W(CRD_W), .PANEL_W(PANEL_W), .PANEL_H(PANEL_H)) u_dirty (
        .clk(clk), .rst_n(rst_n), .refresh_done(refresh_done),
        .invalidate(invalidate), .commit(commit),
        .cm_x0(cm_x0), .cm_x1(cm_x1), .cm_y0(cm_y0), .cm_y1(cm_y1),
        .x0(dirty_x0), .x1(dirty_x1), .y0(dirty_y0), .y1(dirty_y1),
        .none(dirty_none)
    );

endmodule

// File: tb/win_xfer_engine_tb_top.sv
module win_xfer_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CRD_W = 10;
    localparam int PW = 320;
    localparam int PH = 240;
    localparam int CW = 2 * CRD_W + 2;
    localparam int AW = CRD_W + $clog2(PW) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = 3'd0;
    logic [CRD_W-1:0] cfg_wdata = '0;
    logic dp_we = 1'b0;
    logic [15:0] dp_wdata = '0;
    logic refresh_done = 1'b0;
    logic invalidate = 1'b0;
    logic fb_we, busy, xfer_done, setup_err, dirty_none;
    logic [AW-1:0] fb_addr;
    logic [1:0] fb_byte;
    logic [15:0] fb_wdata;
    logic [CW-1:0] words_left;
    logic [CRD_W:0] dirty_x0, dirty_x1, dirty_y0, dirty_y1;

    win_xfer_engine #(.CRD_W(CRD_W), .PANEL_W(PW), .PANEL_H(PH)) dut_i (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    int m_xs = 0, m_xe = 0, m_ys = 0, m_ye = 0, m_fmt = 3, m_src = 0;
    int m_pend = 0, m_rem = 0, m_col = 0, m_byte = 0, m_row = 0;
    int w_xs, w_xe, w_ys, w_ye, w_bpp;
    int d_x0 = PW, d_x1 = 0, d_y0 = PH, d_y1 = 0;

    function automatic int fbpp(int f);
        if (f == 1) return 2;
        if (f == 2 || f == 3) return 3;
        if (f == 6 || f == 7) return 4;
        return 0;
    endfunction

    task automatic chk(string req, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // try setup from current reference registers; returns 1 on success
    function automatic int m_setup();
        int b = fbpp(m_fmt);
        if (m_src > 3 || b == 0 || m_xe < m_xs || m_ye < m_ys) return 0;
        w_xs = m_xs; w_xe = m_xe; w_ys = m_ys; w_ye = m_ye; w_bpp = b;
        m_rem = (b * (m_xe - m_xs + 1) * (m_ye - m_ys + 1)) / 2;
        m_col = 0; m_byte = 0; m_row = 0; m_pend = 1;
        return 1;
    endfunction

    task automatic step(input bit cwe, input int sel, input int val,
                        input bit dwe, input int data, input bit rf, input bit inv);
        int e_err = 0, e_we = 0, e_done = 0, e_addr = 0, e_byte = 0;
        int commit = 0;
        cfg_we = cwe; cfg_sel = 3'(sel); cfg_wdata = CRD_W'(val);
        dp_we = dwe; dp_wdata = 16'(data);
        refresh_done = rf; invalidate = inv;
        @(posedge clk);
        #1;
        cfg_we = 1'b0; dp_we = 1'b0; refresh_done = 1'b0; invalidate = 1'b0;
        if (cwe) begin
            case (sel)
                0: m_xs = val;
                1: m_xe = val;
                2: m_ys = val;
                3: m_ye = val;
                4: m_fmt = val & 15;
                5: begin
                    m_src = val & 7;
                    if (m_setup() == 0) e_err = 1;
                end
                default: ;
            endcase
        end
        if (dwe) begin
            if (!m_pend && m_setup() == 0) e_err = 1;
            else begin
                e_we = 1;
                e_addr = (w_ys + m_row) * PW + w_xs + m_col;
                e_byte = m_byte;
                m_byte += 2;
                if (m_byte >= w_bpp) begin
                    m_byte -= w_bpp;
                    m_col++;
                    if (m_col == w_xe - w_xs + 1) begin m_col = 0; m_row++; end
                end
                m_rem--;
                if (m_rem == 0) begin m_pend = 0; e_done = 1; commit = 1; end
            end
        end
        if (rf) begin d_x0 = PW; d_x1 = 0; d_y0 = PH; d_y1 = 0; end
        if (commit) begin
            if (w_xs < d_x0) d_x0 = w_xs;
            if (w_xe + 1 > d_x1) d_x1 = w_xe + 1;
            if (w_ys < d_y0) d_y0 = w_ys;
            if (w_ye + 1 > d_y1) d_y1 = w_ye + 1;
        end
        if (inv) begin d_x0 = 0; d_x1 = PW; d_y0 = 0; d_y1 = PH; end

        chk("R3/R7", "setup_err", int'(setup_err), e_err);
        chk("R9", "fb_we", int'(fb_we), e_we);
        if (e_we) begin
            chk("R8", "fb_addr", int'(fb_addr), e_addr);
            chk("R8", "fb_byte", int'(fb_byte), e_byte);
            chk("R9", "fb_wdata", int'(fb_wdata), data & 16'hffff);
        end
        chk("R10", "xfer_done", int'(xfer_done), e_done);
        chk("R4", "busy", int'(busy), m_pend);
        chk("R4", "words_left", int'(words_left), m_pend ? m_rem : 0);
        chk("R11", "dirty_x0", int'(dirty_x0), d_x0);
        chk("R11", "dirty_x1", int'(dirty_x1), d_x1);
        chk("R11", "dirty_y0", int'(dirty_y0), d_y0);
        chk("R11", "dirty_y1", int'(dirty_y1), d_y1);
        chk("R14", "dirty_none", int'(dirty_none), (d_x1 <= d_x0) ? 1 : 0);
    endtask

    task automatic set_win(int xs, int xe, int ys, int ye, int fmt);
        step(1, 0, xs, 0, 0, 0, 0);
        step(1, 1, xe, 0, 0, 0, 0);
        step(1, 2, ys, 0, 0, 0, 0);
        step(1, 3, ye, 0, 0, 0, 0);
        step(1, 4, fmt, 0, 0, 0, 0);
    endtask

    task automatic drain();
        while (m_pend) step(0, 0, 0, 1, int'($urandom & 16'hffff), 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "words_left", int'(words_left), 0);
        chk("R1", "fb_we", int'(fb_we), 0);
        chk("R1", "dirty_x0", int'(dirty_x0), PW);
        chk("R1", "dirty_y1", int'(dirty_y1), 0);
        chk("R1", "dirty_none", int'(dirty_none), 1);

        // R2: default format 3 (3 bytes), 1x1 window -> 1 word via implicit setup (R7)
        step(0, 0, 0, 1, 16'h1234, 0, 0);
        // R2: codes 6 and 7 ignored as selects
        step(1, 6, 5, 0, 0, 0, 0);
        step(1, 7, 9, 0, 0, 0, 0);

        // R3: rejections
        set_win(10, 12, 4, 5, 0);          // bpp 0
        step(1, 5, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 16'haaaa, 0, 0);  // R7 dropped word
        set_win(12, 10, 4, 5, 1);          // xe < xs
        step(1, 5, 0, 0, 0, 0, 0);
        set_win(10, 12, 6, 5, 1);          // ye < ys
        step(1, 5, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 16'h5555, 0, 0);
        set_win(10, 12, 4, 5, 6);
        step(1, 5, 12'h00c, 0, 0, 0, 0);   // R5: 0x0C -> source 4 rejected
        step(1, 5, 12'h00b, 0, 0, 0, 0);   // R5: 0x0B -> source 3 accepted
        // R6: restart mid-stream
        step(0, 0, 0, 1, 16'h0101, 0, 0);
        step(0, 0, 0, 1, 16'h0202, 0, 0);
        step(1, 5, 2, 0, 0, 0, 0);
        drain();
        // R8: 3-byte pixels across row wraps
        set_win(7, 9, 3, 5, 2);
        step(1, 5, 0, 0, 0, 0, 0);
        drain();
        // R13 then R12 refresh alone, then R12 refresh with same-cycle commit
        step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1, 0);
        set_win(20, 21, 30, 30, 1);
        step(0, 0, 0, 1, 16'h1111, 0, 0);
        step(0, 0, 0, 1, 16'h2222, 1, 0);
        // R13 overrides commit and refresh
        set_win(50, 50, 60, 60, 1);
        step(0, 0, 0, 1, 16'h3333, 1, 1);

        // random windows
        for (int it = 0; it < 60; it++) begin
            int xs = int'($urandom % 300);
            int ys = int'($urandom % 220);
            int fsel = int'($urandom % 6);
            int fmt = (fsel == 0) ? 1 : (fsel == 1) ? 2 : (fsel == 2) ? 3 :
                      (fsel == 3) ? 6 : (fsel == 4) ? 7 : 4;
            set_win(xs, xs + int'($urandom % 6), ys, ys + int'($urandom % 6), fmt);
            if ($urandom % 2) step(1, 5, int'($urandom % 5), 0, 0, 0, 0);
            step(0, 0, 0, 1, int'($urandom & 16'hffff), 0, 0);
            drain();
            if ($urandom % 4 == 0) step(0, 0, 0, 0, 0, 1, 0);
            if ($urandom % 9 == 0) step(0, 0, 0, 0, 0, 0, 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule